// File: doc/BRIEF.md
# Power-good start-up sequencer

This block steps a single-phase buck converter from power-up to regulated operation and produces its power-good flag. Until the supply is valid and the converter is enabled, it asks the gate drivers to go high-impedance. After enable, it runs soft-start. It then holds at the boot voltage. It waits until the output is within the boot limits and the neighbouring rails report good through the shared power-good pin, which acts as an input at this stage.

At that point the block allows the voltage-identification code to be captured and starts a delay counter. The counter is clocked by the switching-cycle strobe. Power-good can rise only after the programmed number of strobes has been counted. From then on, the pin acts as an output. The output is dropped while the sensed voltage is outside the regulation window, while a setpoint or mode transition is in progress, and whenever a protection fault has latched the converter off.

The states are OFF, SOFTSTART, BOOT_WAIT, DELAY, RUN and FAULT. Dropping enable, or asserting power-on reset, returns the block to OFF from any state.

Top module: `pwrgood_seq`

## Requirements
- R1: While `por_active` is 1, the block goes to OFF: `drv_tristate` is 1 and `ss_enable`, `vid_capture_en` and `pwr_good` are 0 from the next clock edge.
- R2: OFF moves to SOFTSTART at the first edge where `por_active` is 0 and `enable` is 1. Then `ss_enable` is 1 and `drv_tristate` is 0.
- R3: SOFTSTART moves to BOOT_WAIT once `out_in_window` is 1. In SOFTSTART and BOOT_WAIT, `vid_capture_en` stays 0 however long `ext_good` stays low.
- R4: BOOT_WAIT moves to DELAY at the first edge with `out_in_window` and `ext_good` both 1. In DELAY, `vid_capture_en` is 1 and `ss_enable` stays 1.
- R5: The block leaves DELAY for RUN on the edge that carries the DELAY_TICKS-th strobe of `cycle_tick` (default 3072). Only strobes count, not clock cycles. In RUN, `ss_enable` is 0 and `vid_capture_en` is 1. `pwr_good` rises one edge after RUN is entered.
- R6: `pwr_good` is a register. It is 1 only if, at the previous edge, the state was RUN, `out_in_window` was 1 and `setpoint_busy` was 0. A window violation or a busy setpoint drops it without leaving RUN.
- R7: `fault_latched` in any state other than OFF moves to FAULT. FAULT sets `drv_tristate` to 1 and `pwr_good` to 0, and it is left only by dropping `enable`.
- R8: `enable` at 0 returns the block to OFF from any state on the next edge.
- R9: The delay counter is cleared whenever DELAY is left, so a restart needs the full DELAY_TICKS strobes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_active | input | 1 | Supply below power-on threshold |
| enable | input | 1 | Converter enable |
| ext_good | input | 1 | Neighbouring rails report good (pin sensed as input) |
| cycle_tick | input | 1 | One-cycle strobe per switching period |
| out_in_window | input | 1 | Sensed output inside the regulation window |
| setpoint_busy | input | 1 | VID or mode transition in progress |
| fault_latched | input | 1 | Protection fault has latched the converter off |
| drv_tristate | output | 1 | Request both gate drives high-impedance |
| ss_enable | output | 1 | Soft-start reference ramp enabled |
| vid_capture_en | output | 1 | Allow capture of the VID code |
| pwr_good | output | 1 | Registered power-good output |

## Verification
The delay boundary is probed one strobe short and exactly at the count. A design whose counter is off by one would enter RUN a strobe early or late. A design that counts clocks instead of strobes would finish long before the required number of strobes.

One test aborts a partly counted delay and restarts. If the counter were not cleared, power-good would appear before a fresh full delay had passed.

Other tests hold `ext_good` low in BOOT_WAIT, assert setpoint-busy in RUN, and drop the window in RUN. A sequencer that captured VID too early, or did not mask power-good, would show that on the ports. The fault test releases `fault_latched` while enable stays high. A design that left FAULT on its own would release the drivers.

// File: rtl/pwrgood_seq.sv
module pwrgood_seq #(
  parameter int DELAY_TICKS = 3072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_active,
  input  logic enable,
  input  logic ext_good,
  input  logic cycle_tick,
  input  logic out_in_window,
  input  logic setpoint_busy,
  input  logic fault_latched,
  output logic drv_tristate,
  output logic ss_enable,
  output logic vid_capture_en,
  output logic pwr_good
);

  localparam int CW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  typedef enum logic [2:0] {
    S_OFF, S_SOFTSTART, S_BOOT_WAIT, S_DELAY, S_RUN, S_FAULT
  } state_t;

  state_t state, nxt;
  logic [CW-1:0] cnt;
  logic done;

  assign done = (state == S_DELAY) && cycle_tick && (cnt == LAST);

  always_comb begin
    nxt = state;
    case (state)
      S_OFF:       nxt = S_SOFTSTART;
      S_SOFTSTART: if (out_in_window) nxt = S_BOOT_WAIT;
      S_BOOT_WAIT: if (out_in_window && ext_good) nxt = S_DELAY;
      S_DELAY:     if (done) nxt = S_RUN;
      S_RUN:       nxt = S_RUN;
      default:     nxt = S_FAULT;
    endcase
    if (fault_latched && state != S_OFF) nxt = S_FAULT;
    if (por_active || !enable) nxt = S_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != S_DELAY)  cnt <= '0;
      else if (cycle_tick) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_good <= 1'b0;
    else pwr_good <= (state == S_RUN) && out_in_window && !setpoint_busy &&
                     !fault_latched && enable && !por_active;
  end

  assign drv_tristate   = (state == S_OFF) || (state == S_FAULT);
  assign ss_enable      = (state == S_SOFTSTART) || (state == S_BOOT_WAIT) ||
                          (state == S_DELAY);
  assign vid_capture_en = (state == S_DELAY) || (state == S_RUN);

endmodule

// File: rtl/pwrgood_seq_chk.sv
module pwrgood_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic por_active,
  input logic enable,
  input logic ext_good,
  input logic out_in_window,
  input logic setpoint_busy,
  input logic fault_latched,
  input logic drv_tristate,
  input logic ss_enable,
  input logic vid_capture_en,
  input logic pwr_good
);

  assert_tristate_por_R1: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |=> drv_tristate && !pwr_good);

  assert_start_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_enable) |-> $past(enable) && !$past(por_active));

  assert_capture_needs_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_capture_en) |-> $past(ext_good) && $past(out_in_window));

  assert_pg_after_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> vid_capture_en || !$past(enable) || $past(por_active) || $past(fault_latched));

  assert_pg_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> $past(out_in_window) && !$past(setpoint_busy));

  assert_pg_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> !$past(fault_latched));

  assert_disable_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> drv_tristate && !ss_enable && !vid_capture_en);

endmodule

bind pwrgood_seq pwrgood_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_active(por_active), .enable(enable),
  .ext_good(ext_good), .out_in_window(out_in_window),
  .setpoint_busy(setpoint_busy), .fault_latched(fault_latched),
  .drv_tristate(drv_tristate), .ss_enable(ss_enable),
  .vid_capture_en(vid_capture_en), .pwr_good(pwr_good)
);

// File: tb/test_pwrgood_seq.sv
module test_pwrgood_seq;
  localparam int N = 3072;

  logic clk = 1'b0, rst_n = 1'b0;
  logic por_active = 1'b1, enable = 1'b0, ext_good = 1'b0, cycle_tick = 1'b0;
  logic out_in_window = 1'b0, setpoint_busy = 1'b0, fault_latched = 1'b0;
  logic drv_tristate, ss_enable, vid_capture_en, pwr_good;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  pwrgood_seq #(.DELAY_TICKS(N)) i_pwrgood_seq (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {tri,ss,vid,pg} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {drv_tristate, ss_enable, vid_capture_en, pwr_good};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      cycle_tick = 1'b1; cyc(1);
      cycle_tick = 1'b0; cyc(1);
    end
  endtask

  task automatic to_delay();
    por_active = 0; enable = 1; out_in_window = 0; ext_good = 0; cyc(1);
    chk("R2 softstart", outs(), 4'b0100);
    out_in_window = 1; cyc(1);
    ext_good = 0; cyc(5);
    chk("R3 boot wait no capture", outs(), 4'b0100);
    ext_good = 1; cyc(1);
    chk("R4 delay capture", outs(), 4'b0110);
  endtask

  task automatic t_reset_por();
    cyc(2); rst_n = 1; cyc(2);
    chk("R1 por off", outs(), 4'b1000);
    enable = 1; cyc(3);
    chk("R1 por holds off with enable", outs(), 4'b1000);
  endtask

  task automatic t_full_startup();
    to_delay();
    cyc(20);
    chk("R5 clocks without strobes stay in delay", outs(), 4'b0110);
    ticks(N - 1);
    chk("R5 one strobe short", outs(), 4'b0110);
    cycle_tick = 1; cyc(1); cycle_tick = 0;
    chk("R5 run entered pg pending", outs(), 4'b0010);
    cyc(1);
    chk("R5 pg high", outs(), 4'b0011);
  endtask

  task automatic t_mask();
    setpoint_busy = 1; cyc(1);
    chk("R6 busy masks pg", outs(), 4'b0010);
    setpoint_busy = 0; cyc(1);
    chk("R6 busy cleared", outs(), 4'b0011);
    out_in_window = 0; cyc(1);
    chk("R6 window masks pg", outs(), 4'b0010);
    out_in_window = 1; cyc(1);
    chk("R6 window restored", outs(), 4'b0011);
  endtask

  task automatic t_fault();
    fault_latched = 1; cyc(1);
    chk("R7 fault entered", outs(), 4'b1000);
    fault_latched = 0; cyc(4);
    chk("R7 fault sticky", outs(), 4'b1000);
    enable = 0; cyc(1);
    chk("R8 fault to off", outs(), 4'b1000);
  endtask

  task automatic t_abort_delay();
    to_delay();
    ticks(100);
    enable = 0; cyc(1);
    chk("R8 off from delay", outs(), 4'b1000);
    to_delay();
    ticks(N - 1);
    chk("R9 counter cleared on abort", outs(), 4'b0110);
    ticks(1); cyc(1);
    chk("R9 run after fresh count", outs(), 4'b0011);
    por_active = 1; cyc(1);
    chk("R1 por from run", outs(), 4'b1000);
  endtask

  initial begin
    t_reset_por();
    t_full_startup();
    t_mask();
    t_fault();
    t_abort_delay();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1600000;
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule